// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is the shared scratchpad of one SIMD group. Sixteen lanes issue one request together. Each lane supplies an active bit, a write flag, a byte address and a 32-bit write word. The storage totals 16 KB. It is split into 16 single-ported banks of 256 words each. Word addresses are interleaved, so neighbouring words fall in neighbouring banks.

A bank can serve one word per cycle. When several lanes target different words of the same bank, the block replays the request over several passes. In each pass a bank serves the word asked for by its lowest pending lane, together with every other lane that wants that same word. Lanes that read one shared word all receive it from a single access. When the last pass finishes, the block raises a one-cycle `done` strobe and presents the read data for every lane.

A state machine controls the sequence. It has three states:
- `S_IDLE`: waiting. `ready` is high, and the request is latched on the transition `IDLE->PASS`, which happens when `req_valid` is high.
- `S_PASS`: one bank access per bank per cycle. It stays in `PASS->PASS` while any lane is still pending, and moves `PASS->DONE` once the final lane is served.
- `S_DONE`: the strobe cycle. It always returns `DONE->IDLE`.

Top module: `banked_scratchpad`

## Requirements
- R1: A byte address splits into a byte offset in bits [1:0], a bank index in bits [5:2] (word address modulo 16) and a row in bits [13:6] (word address divided by 16). A word written by one request reads back at the same byte address in any later request.
- R2: A request whose active lanes all fall in different banks completes in a single pass.
- R3: The `done` strobe rises on the P-th rising edge after the edge that accepts the request. P is the largest number of distinct words requested in any one bank, and P is at least 1.
- R4: Lanes reading the same word receive identical data in the same pass. This does not add passes.
- R5: When several served lanes write the same word, the value from the highest lane index is stored.
- R6: A lane that reads a word being written in the same pass receives the value held before that pass.
- R7: A lane that is inactive, writing or misaligned returns zero read data. An inactive lane writes nothing.
- R8: `err` is set at acceptance when any active lane has a nonzero byte offset. Such lanes are dropped and do not write. `err` holds until the next accepted request, which recomputes it.
- R9: `done` lasts one cycle and is followed by `ready`. `req_valid` is ignored while `ready` is low. `rd_data` and `err` do not change while idle.
- R10: After reset, `ready` is 1, `done` is 0, `err` is 0 and every lane's `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Present a group request (taken when ready) |
| lane_active | input | 16 | Per-lane request enable |
| lane_we | input | 16 | Per-lane write flag |
| lane_addr | input | 16x14 | Per-lane byte address |
| lane_wdata | input | 16x32 | Per-lane write word |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle strobe when every lane is served |
| err | output | 1 | Misaligned active lane in the last request |
| rd_data | output | 16x32 | Per-lane read result, valid from done |

## Verification
The bench sweeps lane strides from 0 to 16 and degrees of same-bank collision from 1 to 16, and checks that the latency equals the deepest per-bank word count. A design that counts lanes rather than distinct words, or that treats a broadcast as a conflict, shows up as a wrong cycle count. Same-word write collisions expose a design that lets the wrong lane win. Mixed read/write passes expose one that forwards new data to readers. Inactive and misaligned lanes expose stray writes. A second request held during a pass exposes an engine that re-latches inputs in mid-flight; that shows up later as corrupted read-back data.

// File: rtl/sp_pkg.sv
package sp_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PASS = 2'd1,
        S_DONE = 2'd2
    } sp_state_t;
endpackage

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
    parameter int LANES   = 16,
    parameter int BANK_W  = 4,
    parameter int ROW_W   = 8,
    parameter int DATA_W  = 32,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]             pend,
    input  logic [LANES-1:0]             we,
    input  logic [LANES-1:0][BANK_W-1:0] bank,
    input  logic [LANES-1:0][ROW_W-1:0]  row,
    input  logic [LANES-1:0][DATA_W-1:0] wdata,
    output logic [LANES-1:0]             serve,
    output logic [ROW_W-1:0]             sel_row,
    output logic                         wr_en,
    output logic [DATA_W-1:0]            wr_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LANES-1:0] hit;

    // lanes still pending that map to this bank
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pend[l] && (bank[l] == BANK_W'(BANK_ID));
        end
    end

    // the lowest hitting lane picks the row; a later (higher) writer overrides an earlier one
    always_comb begin
        sel_row = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (hit[l]) sel_row = row[l];
        end
        wr_en   = 1'b0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            serve[l] = hit[l] && (row[l] == sel_row);
            if (serve[l] && we[l]) begin
                wr_en   = 1'b1;
                wr_data = wdata[l];
            end
        end
    end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int ROW_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[row] <= wdata;
    end

    assign rdata = mem[row];
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad
    import sp_pkg::*;
#(
    parameter int LANES      = 16,
    parameter int BANKS      = 16,
    parameter int BANK_WORDS = 256,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = $clog2(BANKS * BANK_WORDS * (DATA_W / 8))
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [LANES-1:0]             lane_active,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0][DATA_W-1:0] lane_wdata,
    output logic                         ready,
    output logic                         done,
    output logic                         err,
    output logic [LANES-1:0][DATA_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OFS_W  = $clog2(DATA_W / 8);
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = $clog2(BANK_WORDS);

    sp_state_t state_q, state_nx;

    logic [LANES-1:0]             pend_q;
    logic [LANES-1:0]             we_q;
    logic [LANES-1:0][BANK_W-1:0] bank_q;
    logic [LANES-1:0][ROW_W-1:0]  row_q;
    logic [LANES-1:0][DATA_W-1:0] wdata_q;
    logic [LANES-1:0][DATA_W-1:0] rd_q;
    logic                         err_q;

    logic [BANKS-1:0][LANES-1:0]  serve_b;
    logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [LANES-1:0]             served;
    logic [LANES-1:0]             misalign;
    logic                         accept;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ROW_W-1:0]  sel_row;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;

        sp_bank_arbiter #(
            .LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W),
            .DATA_W(DATA_W), .BANK_ID(b)
        ) u_arb (
            .pend(pend_q), .we(we_q), .bank(bank_q), .row(row_q),
            .wdata(wdata_q), .serve(serve_b[b]), .sel_row(sel_row),
            .wr_en(wr_en), .wr_data(wr_data)
        );

        sp_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_mem (
            .clk(clk), .wr_en(wr_en && (state_q == S_PASS)), .row(sel_row),
            .wdata(wr_data), .rdata(bank_rdata[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) served |= serve_b[b];
        for (int l = 0; l < LANES; l++) begin
            misalign[l] = lane_addr[l][OFS_W-1:0] != '0;
        end
    end

    assign accept = (state_q == S_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_nx = req_valid ? S_PASS : S_IDLE;
            S_PASS:  state_nx = ((pend_q & ~served) == '0) ? S_DONE : S_PASS;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request latch and per-pass bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            rd_q   <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            pend_q <= lane_active & ~misalign;
            err_q  <= |(lane_active & misalign);
            for (int l = 0; l < LANES; l++) begin
                we_q[l]    <= lane_we[l];
                bank_q[l]  <= lane_addr[l][OFS_W +: BANK_W];
                row_q[l]   <= lane_addr[l][OFS_W+BANK_W +: ROW_W];
                wdata_q[l] <= lane_wdata[l];
                rd_q[l]    <= '0;
            end
        end else if (state_q == S_PASS) begin
            pend_q <= pend_q & ~served;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !we_q[l]) rd_q[l] <= bank_rdata[bank_q[l]];
            end
        end
    end

    // outputs
    always_comb begin
        ready   = (state_q == S_IDLE);
        done    = (state_q == S_DONE);
        err     = err_q;
        rd_data = rd_q;
    end
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int LANES  = 16,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         ready,
    input logic                         done,
    input logic                         err,
    input logic [LANES-1:0][DATA_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && ready) |=> $stable(err));

    assert_rd_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req_valid) |=> $stable(rd_data));

    assert_done_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && ready));
endmodule

bind banked_scratchpad sp_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
    .done(done), .err(err), .rd_data(rd_data)
);

// File: tb/banked_scratchpad_bench.sv
module banked_scratchpad_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int L = 16;
    localparam int NW = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [L-1:0] lane_active = '0;
    logic [L-1:0] lane_we = '0;
    logic [L-1:0][13:0] lane_addr = '0;
    logic [L-1:0][31:0] lane_wdata = '0;
    logic ready, done, err;
    logic [L-1:0][31:0] rd_data;

    int n_total = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] shadow [NW];

    always #4 clk = ~clk;

    banked_scratchpad u_banked_scratchpad (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .lane_active(lane_active), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .ready(ready), .done(done), .err(err),
        .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // issue one group request from the lane_* values already set; model expectations
    task automatic issue(input string tag);
        logic [L-1:0] ok;
        int word [L];
        int passes, cnt;
        logic exp_err;
        logic [31:0] exp_rd [L];
        exp_err = 1'b0;
        for (int l = 0; l < L; l++) begin
            ok[l] = lane_active[l] && (lane_addr[l][1:0] == 2'b00);
            if (lane_active[l] && !ok[l]) exp_err = 1'b1;
            word[l] = int'(lane_addr[l] >> 2);
            exp_rd[l] = (ok[l] && !lane_we[l]) ? shadow[word[l]] : 32'h0;
        end
        passes = 1;
        for (int b = 0; b < 16; b++) begin
            int distinct = 0;
            for (int l = 0; l < L; l++) begin
                bit fresh = ok[l] && (word[l] % 16 == b);
                for (int k = 0; k < l; k++)
                    if (ok[k] && word[k] == word[l]) fresh = 1'b0;
                if (fresh) distinct++;
            end
            if (distinct > passes) passes = distinct;
        end
        for (int l = 0; l < L; l++)
            if (ok[l] && lane_we[l]) shadow[word[l]] = lane_wdata[l];

        while (!ready) begin @(posedge clk); #1; end
        req_valid = 1'b1;
        @(posedge clk); #1;
        // second request during the pass must be ignored (R9)
        lane_wdata = ~lane_wdata;
        lane_we = '1;
        lane_active = '1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        cnt = 1;
        while (!done && cnt < 40) begin @(posedge clk); #1; cnt++; end
        chk(cnt == passes, "R3", "pass count", cnt, passes);
        chk(err == exp_err, "R8", "err flag", err, exp_err);
        for (int l = 0; l < L; l++)
            chk(rd_data[l] == exp_rd[l], tag, $sformatf("lane %0d data", l), rd_data[l], exp_rd[l]);
        @(posedge clk); #1;
        chk(ready && !done, "R9", "ready after done", {ready, done}, 2'b10);
    endtask

    task automatic set_lane(input int l, input bit act, input bit we, input int w, input logic [31:0] d);
        lane_active[l] = act;
        lane_we[l] = we;
        lane_addr[l] = 14'(w * 4);
        lane_wdata[l] = d;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(ready == 1'b1 && done == 1'b0 && err == 1'b0, "R10", "reset flags",
            {ready, done, err}, 3'b100);
        chk(rd_data == '0, "R10", "reset data", rd_data[0], 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1/R2: fill every word, conflict-free
        for (int r = 0; r < 256; r++) begin
            for (int l = 0; l < L; l++)
                set_lane(l, 1, 1, r * 16 + l, (r * 16 + l) * 32'h9E3779B1 ^ 32'h5A5A0F0F);
            issue("R2");
        end
        // R1: read everything back with permuted lanes
        for (int r = 0; r < 256; r++) begin
            for (int l = 0; l < L; l++)
                set_lane(l, 1, 0, r * 16 + ((l * 5 + 3) % 16), 0);
            issue("R1");
        end
        // R3/R4: stride sweep, stride 0 is a full broadcast
        for (int s = 0; s <= 16; s++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, 0, (100 + l * s) % NW, 0);
            issue(s == 0 ? "R4" : "R3");
        end
        // R3: collision degree sweep in one bank, reads then writes
        for (int d = 1; d <= 16; d++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, 0, (l % d) * 48 + 7, 0);
            issue("R4");
            for (int l = 0; l < L; l++) set_lane(l, 1, 1, (l % d) * 48 + 7, 32'h1000 * d + l);
            issue("R3");
        end
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, (l % 16) * 48 + 7, 0);
        issue("R5");
        // R5: all lanes write one word, highest lane wins
        for (int l = 0; l < L; l++) set_lane(l, 1, 1, 50, 1000 + l);
        issue("R5");
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 50, 0);
        issue("R5");
        // R5/R7: partial active mask on a write collision
        for (int l = 0; l < L; l++) set_lane(l, ((16'h0F0F >> l) & 1) != 0, 1, 51, 2000 + l);
        issue("R7");
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 51, 0);
        issue("R5");
        // R6: readers of a word written in the same pass see the old value
        for (int l = 0; l < L; l++) set_lane(l, 1, (l % 2) == 0, 60, 32'hABC0 + l);
        issue("R6");
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 60, 0);
        issue("R6");
        // R7: inactive lanes write nothing and return zero
        foreach (shadow[i]) begin end
        for (int m = 0; m < 4; m++) begin
            logic [15:0] mask;
            mask = (m == 0) ? 16'h0000 : (m == 1) ? 16'hAAAA : (m == 2) ? 16'h8001 : 16'h7FFE;
            for (int l = 0; l < L; l++) set_lane(l, mask[l], 1, 300 + l, 32'hC000 + m * 16 + l);
            issue("R7");
            for (int l = 0; l < L; l++) set_lane(l, 1, 0, 300 + l, 0);
            issue("R7");
            for (int l = 0; l < L; l++) set_lane(l, mask[l], 0, 300 + l, 0);
            issue("R7");
        end
        // R8: misaligned lane is dropped and flags err; next request clears it
        for (int l = 0; l < L; l++) set_lane(l, 1, 1, 400 + l, 32'hD000 + l);
        lane_addr[3] = lane_addr[3] | 14'd1;
        issue("R8");
        chk(err == 1'b1, "R8", "err held while idle", err, 1);
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 400 + l, 0);
        issue("R8");
        chk(err == 1'b0, "R8", "err cleared", err, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule